// File: doc/BRIEF.md
# RGB Dot-Clock Video Timing Generator

This block drives a parallel RGB panel from a single dot clock. It counts dot clocks across each line and lines across each frame. From those counts it produces active-low horizontal and vertical sync, and a data-enable that marks the visible window. During that window it sends pixels on an 8-bit bus. Each 24-bit pixel takes three consecutive dot clocks: red first, then green, then blue. A byte-phase output gives the slot index within the pixel. All panel-facing outputs are launched from the falling edge of the dot clock, so a panel that samples on the rising edge sees stable values.

Pixels come from a ready/valid stream of 24-bit words. The block raises ready only in the first byte slot of each visible pixel. If no word is offered at that moment, the block sends a black pixel and sets a sticky underflow flag, which stays set until it is cleared. A one-cycle pulse marks each assertion of vertical sync, so other logic can align to frame starts.

The default geometry is 320x240 visible pixels at three clocks per pixel. Horizontal timing uses a sync width of 8, a back porch of 24 and a front porch of 4 clocks. Vertical timing uses a sync width of 1, a back porch of 3 and a front porch of 1 line. These limits apply:
- The horizontal back porch lies between 24 and 1533 clocks and exceeds the horizontal sync width.
- The horizontal front porch is at least 4 clocks.
- The vertical back porch lies between 3 and 257 lines and exceeds the vertical sync width.
- The vertical front porch is at least 1 line.

Both back porches are counted from the start of the sync pulse, so each includes the sync width. With a 24 MHz dot clock the defaults give close to 100 frames per second.

Top module: `rgb_dotclk_timing`

## Requirements
- R1: A line lasts HB + HA*CPP + HF dot clocks, where HB is the horizontal back porch, HA the visible pixels per line, CPP the clocks per pixel and HF the horizontal front porch. `hsync_n` is low for the first HP clocks of each line (HP = horizontal sync width) and high for the rest.
- R2: A frame lasts VB + VA + VF lines, where VB is the vertical back porch, VA the visible lines and VF the vertical front porch. `vsync_n` is low for the first VP lines (VP = vertical sync width). The line count advances when a line ends.
- R3: `lcd_de` is high exactly when the line position is in [HB, HB+HA*CPP) and the line number is in [VB, VB+VA). Whenever `lcd_de` is low, `lcd_data` and `byte_phase` are zero.
- R4: Inside the window, each pixel occupies CPP consecutive clocks with `byte_phase` counting 0, 1, 2. The bytes sent are bits [23:16] (red), then [15:8] (green), then [7:0] (blue) of the word accepted for that pixel.
- R5: `pix_ready` is high only in the clock that produces byte phase 0 of a visible pixel. Exactly one word is accepted per visible pixel, and pixels are sent in stream order.
- R6: If `pix_valid` is low while `pix_ready` is high, that pixel is sent as three zero bytes and `underflow` becomes 1 at the next rising edge. `underflow` then stays 1 until a rising edge with `underflow_clr` high; a new underflow in the same cycle takes priority over the clear.
- R7: `vsync_pulse` is high for exactly one clock, in the clock in which `vsync_n` first goes low for a frame. It is never high otherwise.
- R8: `hsync_n`, `vsync_n`, `lcd_de`, `lcd_data`, `byte_phase` and `vsync_pulse` change only on falling edges of `clk`. Each carries the value computed at the preceding rising edge.
- R9: While `rst_n` is low: `hsync_n` and `vsync_n` are 1; `lcd_de`, `lcd_data`, `byte_phase`, `vsync_pulse`, `pix_ready` and `underflow` are 0. The first rising edge after release starts line 0, clock 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_data | input | 24 | Pixel word, red in [23:16], green in [15:8], blue in [7:0] |
| pix_valid | input | 1 | Stream has a pixel word |
| pix_ready | output | 1 | Pixel accepted at this rising edge if valid |
| underflow_clr | input | 1 | Clears the sticky underflow flag |
| underflow | output | 1 | Sticky flag: a pixel was due with no word offered |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| lcd_de | output | 1 | Visible-window data enable |
| lcd_data | output | 8 | Byte bus to the panel |
| byte_phase | output | 2 | Byte slot within the current pixel |
| vsync_pulse | output | 1 | One-clock strobe at vertical sync assertion |

## Verification
The bench shrinks the geometry so that several whole frames fit in a short run:
- 4 visible pixels per line at 3 clocks each, with a sync width of 2, a back porch of 5 and a front porch of 2 clocks, giving 19 clocks per line.
- 3 visible lines, with a sync width of 1, a back porch of 2 and a front porch of 1 line, giving 6 lines per frame.

The porches stay larger than the sync widths, so every ordering relation the design depends on still holds. The small sizes make it possible to compare every clock over three frames against an arithmetic model. They also reach the line and frame wraps many times, the pixel-to-pixel handoff inside a line, and a starvation window that falls on visible pixels. A clear pulse after that window completes the sticky-flag test.

// File: rtl/rgbt_pkg.sv
package rgbt_pkg;

    // Sync/enable part of the panel-facing stage
    typedef struct packed {
        logic hs_n;
        logic vs_n;
        logic de;
        logic vpulse;
    } rgbt_ctl_t;

    localparam rgbt_ctl_t RGBT_CTL_IDLE = '{hs_n: 1'b1, vs_n: 1'b1, de: 1'b0, vpulse: 1'b0};

endpackage

// File: rtl/rgbt_axis_counter.sv
// One timing axis: position counter with wrap, sync and window decode
module rgbt_axis_counter #(
    parameter int TOTAL = 16,
    parameter int PULSE = 2,
    parameter int START = 4,
    parameter int LEN   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic sync_on,
    output logic in_win,
    output logic wrap
);
    localparam int CW = (TOTAL > 2) ? $clog2(TOTAL) : 1;
    localparam logic [CW-1:0] LAST_POS  = CW'(TOTAL - 1);
    localparam logic [CW-1:0] SYNC_END  = CW'(PULSE);
    localparam logic [CW-1:0] WIN_START = CW'(START);
    localparam logic [CW-1:0] WIN_END   = CW'(START + LEN);

    logic [CW-1:0] pos_d, pos_q;

    always_comb begin
        wrap    = adv && (pos_q == LAST_POS);
        pos_d   = pos_q;
        if (adv) begin
            pos_d = wrap ? '0 : pos_q + 1'b1;
        end
        sync_on = (pos_q < SYNC_END);
        in_win  = (pos_q >= WIN_START) && (pos_q < WIN_END);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

endmodule

// File: rtl/rgbt_byte_ser.sv
// Pixel fetch and byte serialisation, most significant byte first
module rgbt_byte_ser #(
    parameter int BYTE_W = 8,
    parameter int CPP    = 3,
    parameter int PHW    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  active,
    input  logic [BYTE_W*CPP-1:0] pix_data,
    input  logic                  pix_valid,
    input  logic                  underflow_clr,
    output logic                  pix_ready,
    output logic [BYTE_W-1:0]     byte_nxt,
    output logic [PHW-1:0]        phase_cur,
    output logic                  underflow
);
    localparam int PW = BYTE_W * CPP;
    localparam logic [PHW-1:0] PH_LAST = PHW'(CPP - 1);

    typedef struct packed {
        logic [PHW-1:0] phase;
        logic [PW-1:0]  hold;
        logic           uf;
    } ser_t;

    ser_t st_d, st_q;
    logic due;

    always_comb begin
        st_d     = st_q;
        byte_nxt = '0;
        due      = active && (st_q.phase == '0);

        if (active) begin
            st_d.phase = (st_q.phase == PH_LAST) ? '0 : st_q.phase + 1'b1;
        end else begin
            st_d.phase = '0;
        end

        if (due) begin
            if (pix_valid) begin
                byte_nxt  = pix_data[PW-1 -: BYTE_W];
                st_d.hold = pix_data << BYTE_W;
            end else begin
                byte_nxt  = '0;
                st_d.hold = '0;
            end
        end else if (active) begin
            byte_nxt  = st_q.hold[PW-1 -: BYTE_W];
            st_d.hold = st_q.hold << BYTE_W;
        end else begin
            st_d.hold = '0;
        end

        if (due && !pix_valid) begin
            st_d.uf = 1'b1;
        end else if (underflow_clr) begin
            st_d.uf = 1'b0;
        end

        pix_ready = due;
        phase_cur = st_q.phase;
        underflow = st_q.uf;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rgbt_launch.sv
// Falling-edge launch register for all panel-facing outputs
module rgbt_launch
    import rgbt_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PHW    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rgbt_ctl_t         ctl_in,
    input  logic [BYTE_W-1:0] data_in,
    input  logic [PHW-1:0]    phase_in,
    output rgbt_ctl_t         ctl_out,
    output logic [BYTE_W-1:0] data_out,
    output logic [PHW-1:0]    phase_out
);
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            ctl_out   <= RGBT_CTL_IDLE;
            data_out  <= '0;
            phase_out <= '0;
        end else begin
            ctl_out   <= ctl_in;
            data_out  <= data_in;
            phase_out <= phase_in;
        end
    end

endmodule

// File: rtl/rgb_dotclk_timing.sv
module rgb_dotclk_timing
    import rgbt_pkg::*;
#(
    parameter int H_ACTIVE = 320,
    parameter int H_PULSE  = 8,
    parameter int H_BACK   = 24,
    parameter int H_FRONT  = 4,
    parameter int V_ACTIVE = 240,
    parameter int V_PULSE  = 1,
    parameter int V_BACK   = 3,
    parameter int V_FRONT  = 1,
    parameter int CPP      = 3,
    parameter int BYTE_W   = 8,
    localparam int PHW     = (CPP > 2) ? $clog2(CPP) : 1,
    localparam int PW      = BYTE_W * CPP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PW-1:0]     pix_data,
    input  logic              pix_valid,
    output logic              pix_ready,
    input  logic              underflow_clr,
    output logic              underflow,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              lcd_de,
    output logic [BYTE_W-1:0] lcd_data,
    output logic [PHW-1:0]    byte_phase,
    output logic              vsync_pulse
);
    localparam int H_VIS   = H_ACTIVE * CPP;
    localparam int H_TOTAL = H_BACK + H_VIS + H_FRONT;
    localparam int V_TOTAL = V_BACK + V_ACTIVE + V_FRONT;

    typedef struct packed {
        rgbt_ctl_t         ctl;
        logic [BYTE_W-1:0] data;
        logic [PHW-1:0]    phase;
    } stage_t;

    logic h_sync, h_win, h_wrap;
    logic v_sync, v_win, v_wrap;
    logic active;
    logic [BYTE_W-1:0] ser_byte;
    logic [PHW-1:0]    ser_phase;
    stage_t stg_d, stg_q;
    rgbt_ctl_t ctl_o;

    rgbt_axis_counter #(
        .TOTAL(H_TOTAL), .PULSE(H_PULSE), .START(H_BACK), .LEN(H_VIS)
    ) u_hcnt (
        .clk(clk), .rst_n(rst_n), .adv(1'b1),
        .sync_on(h_sync), .in_win(h_win), .wrap(h_wrap)
    );

    rgbt_axis_counter #(
        .TOTAL(V_TOTAL), .PULSE(V_PULSE), .START(V_BACK), .LEN(V_ACTIVE)
    ) u_vcnt (
        .clk(clk), .rst_n(rst_n), .adv(h_wrap),
        .sync_on(v_sync), .in_win(v_win), .wrap(v_wrap)
    );

    assign active = h_win && v_win;

    rgbt_byte_ser #(
        .BYTE_W(BYTE_W), .CPP(CPP), .PHW(PHW)
    ) u_ser (
        .clk(clk), .rst_n(rst_n), .active(active),
        .pix_data(pix_data), .pix_valid(pix_valid),
        .underflow_clr(underflow_clr), .pix_ready(pix_ready),
        .byte_nxt(ser_byte), .phase_cur(ser_phase), .underflow(underflow)
    );

    always_comb begin
        stg_d.ctl.hs_n   = !h_sync;
        stg_d.ctl.vs_n   = !v_sync;
        stg_d.ctl.de     = active;
        stg_d.ctl.vpulse = stg_q.ctl.vs_n && v_sync;
        stg_d.data       = active ? ser_byte : '0;
        stg_d.phase      = active ? ser_phase : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '{ctl: RGBT_CTL_IDLE, data: '0, phase: '0};
        end else begin
            stg_q <= stg_d;
        end
    end

    rgbt_launch #(
        .BYTE_W(BYTE_W), .PHW(PHW)
    ) u_launch (
        .clk(clk), .rst_n(rst_n),
        .ctl_in(stg_q.ctl), .data_in(stg_q.data), .phase_in(stg_q.phase),
        .ctl_out(ctl_o), .data_out(lcd_data), .phase_out(byte_phase)
    );

    assign hsync_n     = ctl_o.hs_n;
    assign vsync_n     = ctl_o.vs_n;
    assign lcd_de      = ctl_o.de;
    assign vsync_pulse = ctl_o.vpulse;

    logic unused_v_wrap;
    assign unused_v_wrap = v_wrap;

endmodule

// File: rtl/rgbt_checker.sv
module rgbt_checker #(
    parameter int BYTE_W = 8,
    parameter int PHW    = 2,
    parameter int PW     = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PW-1:0]     pix_data,
    input logic              pix_valid,
    input logic              pix_ready,
    input logic              underflow_clr,
    input logic              underflow,
    input logic              hsync_n,
    input logic              vsync_n,
    input logic              lcd_de,
    input logic [BYTE_W-1:0] lcd_data,
    input logic [PHW-1:0]    byte_phase,
    input logic              vsync_pulse
);
    logic [PW-1:0] unused_pix;
    logic          unused_hs;
    assign unused_pix = pix_data;
    assign unused_hs  = hsync_n;

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_de |-> (lcd_data == '0 && byte_phase == '0)); // R3

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_de && byte_phase == '0) |=> (lcd_de && byte_phase == PHW'(1))); // R4

    AST_READY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |=> (lcd_de && byte_phase == '0)); // R5

    AST_UF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ready && !pix_valid) |=> underflow); // R6

    AST_UF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !underflow_clr) |=> underflow); // R6

    AST_VPULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_pulse |=> !vsync_pulse); // R7

    AST_VPULSE_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_pulse |-> !vsync_n); // R7

endmodule

bind rgb_dotclk_timing rgbt_checker #(.BYTE_W(BYTE_W), .PHW(PHW), .PW(PW)) u_chk (.*);

// File: tb/rgb_dotclk_timing_bench.sv
module rgb_dotclk_timing_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HA = 4, HP = 2, HB = 5, HF = 2;
    localparam int VA = 3, VP = 1, VB = 2, VF = 1;
    localparam int CPP = 3;
    localparam int HT = HB + HA * CPP + HF;
    localparam int VT = VB + VA + VF;
    localparam int NCYC = 3 * HT * VT + 12;
    localparam int STARVE_LO = HT * VT + VB * HT;
    localparam int STARVE_HI = STARVE_LO + 10;
    localparam int CLR_AT = 2 * HT * VT + 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [23:0] pix_data = '0;
    logic pix_valid = 1'b0;
    logic pix_ready;
    logic underflow_clr = 1'b0;
    logic underflow;
    logic hsync_n, vsync_n, lcd_de, vsync_pulse;
    logic [7:0] lcd_data;
    logic [1:0] byte_phase;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    logic [7:0] exp_q[$];

    rgb_dotclk_timing #(
        .H_ACTIVE(HA), .H_PULSE(HP), .H_BACK(HB), .H_FRONT(HF),
        .V_ACTIVE(VA), .V_PULSE(VP), .V_BACK(VB), .V_FRONT(VF),
        .CPP(CPP), .BYTE_W(8)
    ) u_rgb_dotclk_timing (
        .clk(clk), .rst_n(rst_n), .pix_data(pix_data), .pix_valid(pix_valid),
        .pix_ready(pix_ready), .underflow_clr(underflow_clr), .underflow(underflow),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .lcd_de(lcd_de), .lcd_data(lcd_data),
        .byte_phase(byte_phase), .vsync_pulse(vsync_pulse)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [23:0] pix_of(input int i);
        return {8'(i * 3 + 1), 8'(i ^ 8'hA5), 8'(8'hF0 - i)};
    endfunction

    function automatic bit vis(input int k);
        int h = k % HT;
        int v = (k / HT) % VT;
        return (h >= HB) && (h < HB + HA * CPP) && (v >= VB) && (v < VB + VA);
    endfunction

    function automatic int phs(input int k);
        return vis(k) ? ((k % HT) - HB) % CPP : 0;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int pix_idx = 0;
        bit fire = 0;
        bit exp_uf = 0;
        logic p_hs, p_vs, p_de, p_vp;
        logic [7:0] p_data;
        logic [1:0] p_ph;

        repeat (3) @(posedge clk);
        #(CLK_PERIOD / 2 + 1);
        // R9 reset state
        check(hsync_n === 1'b1 && vsync_n === 1'b1, "R9 syncs high in reset", hsync_n, 1);
        check(lcd_de === 1'b0 && lcd_data === 8'h00 && byte_phase === 2'd0, "R9 data idle in reset", lcd_data, 0);
        check(pix_ready === 1'b0 && underflow === 1'b0 && vsync_pulse === 1'b0, "R9 ready/flag low in reset", pix_ready, 0);
        p_hs = 1; p_vs = 1; p_de = 0; p_vp = 0; p_data = 0; p_ph = 0;

        @(posedge clk);
        #1;
        rst_n = 1'b1;
        pix_valid = 1'b1;
        pix_data = pix_of(0);

        for (int k = 0; k < NCYC; k++) begin
            int h, v, eph;
            bit ev;
            @(posedge clk);
            #(CLK_PERIOD / 4);
            // R8: nothing panel-facing moves at the rising edge
            check(hsync_n === p_hs && vsync_n === p_vs && lcd_de === p_de &&
                  lcd_data === p_data && byte_phase === p_ph && vsync_pulse === p_vp,
                  "R8 outputs stable across rising edge", lcd_data, p_data);
            check(underflow === exp_uf, "R6 underflow flag", underflow, exp_uf);
            if (fire) begin
                pix_idx++;
                pix_data = pix_of(pix_idx);
            end
            pix_valid = !(k + 1 >= STARVE_LO && k + 1 < STARVE_HI);
            underflow_clr = (k + 1 == CLR_AT);

            #(CLK_PERIOD / 2);
            h = k % HT;
            v = (k / HT) % VT;
            ev = vis(k);
            eph = phs(k);
            check(hsync_n === !(h < HP), "R1 hsync_n", hsync_n, !(h < HP));
            check(vsync_n === !(v < VP), "R2 vsync_n", vsync_n, !(v < VP));
            check(lcd_de === ev, "R3 lcd_de window", lcd_de, ev);
            check(int'(byte_phase) == eph, "R4 byte_phase", byte_phase, eph);
            check(vsync_pulse === (h == 0 && v == 0), "R7 vsync_pulse", vsync_pulse, (h == 0 && v == 0));
            if (ev) begin
                logic [7:0] eb;
                eb = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
                check(lcd_data === eb, "R4 byte order/value", lcd_data, eb);
            end else begin
                check(lcd_data === 8'h00, "R3 idle data zero", lcd_data, 0);
            end
            p_hs = hsync_n; p_vs = vsync_n; p_de = lcd_de;
            p_data = lcd_data; p_ph = byte_phase; p_vp = vsync_pulse;

            // next position k+1: ready slot and scoreboard push
            check(pix_ready === (vis(k + 1) && phs(k + 1) == 0), "R5 pix_ready slot",
                  pix_ready, (vis(k + 1) && phs(k + 1) == 0));
            fire = pix_ready && pix_valid;
            if (pix_ready) begin
                if (pix_valid) begin
                    exp_q.push_back(pix_data[23:16]);
                    exp_q.push_back(pix_data[15:8]);
                    exp_q.push_back(pix_data[7:0]);
                end else begin
                    repeat (3) exp_q.push_back(8'h00); // R6 black pixel
                end
            end
            if (pix_ready && !pix_valid) exp_uf = 1;
            else if (underflow_clr) exp_uf = 0;
        end
        check(exp_q.size() == 0, "R5 all accepted pixels sent", exp_q.size(), 0);
        finish_run();
    end

endmodule